// File: doc/BRIEF.md
# DMA Status and Read-Back Sequencer

This block forms the byte a processor sees when it reads the control port of a DMA channel. With no read-back list set up, every read returns a live status byte. The byte is built on a fixed base pattern. On top of that base it carries the channel-enable flag, a ready-mismatch flag, a no-match flag and a not-at-end-of-block flag.

Software can set a 7-bit selection mask that picks entries from an ordered set of internal values. Those values are the status byte and the low and high bytes of the byte counter, the port A address counter and the port B address counter. Each read then returns the next selected entry in ascending mask-bit order, and wraps from the last selected entry back to the first.

Reads are accepted in every cycle, and there is no back-pressure. `rd_data` is valid during any cycle in which `rd_en` is high. The read is taken at the rising edge that ends that cycle, and that edge moves the sequence pointer on. Loading a mask, restarting the sequence and selecting status-only rebuild the list, and the pointer returns to the first selected entry at the next edge.

Top module: `dma_readback`

## Requirements
- R1: In the status byte, bits 7, 6, 3 and 2 are always 1, and bit 0 equals `chan_en`.
- R2: Status bit 1 is 1 exactly when `xfer_mode` is not 1 and `rdy_pol` differs from `rdy_in`.
- R3: Status bit 4 is the inverse of `match_hit`, and status bit 5 is the inverse of `block_end`.
- R4: Mask bit i selects entry i. The entries are: 0 status, 1 `byte_cnt[7:0]`, 2 `byte_cnt[15:8]`, 3 `a_cnt[7:0]`, 4 `a_cnt[15:8]`, 5 `b_cnt[7:0]`, 6 `b_cnt[15:8]`.
- R5: With a non-empty list, successive reads return the selected entries in ascending index order, and the read after the highest selected entry returns the lowest selected entry again.
- R6: With an empty mask, every read returns the live status byte, and reads change no state.
- R7: A pulse on `mask_we` stores `mask_in` and sets the pointer to the lowest selected entry.
- R8: A pulse on `status_only` sets the mask to status only (value 1) and sets the pointer to entry 0.
- R9: A pulse on `restart_seq` keeps the mask and returns the pointer to the lowest selected entry.
- R10: The status entry returns the status inputs as they are during the read that returns it.
- R11: After reset the mask is empty, so reads return live status.
- R12: When several pulses share one edge, `status_only` takes precedence over `mask_we`, which takes precedence over `restart_seq`. Any rebuild overrides the pointer advance of a read in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe; the read is taken at the rising edge |
| mask_we | input | 1 | Load `mask_in` and rebuild the list |
| mask_in | input | 7 | Selection mask |
| restart_seq | input | 1 | Rebuild the list from the current mask |
| status_only | input | 1 | Set the mask to status only and rebuild |
| chan_en | input | 1 | Channel enabled |
| xfer_mode | input | 2 | Transfer mode |
| rdy_pol | input | 1 | Programmed ready polarity |
| rdy_in | input | 1 | Ready line state |
| match_hit | input | 1 | A match has occurred |
| block_end | input | 1 | End of block reached |
| byte_cnt | input | 16 | Byte counter |
| a_cnt | input | 16 | Port A address counter |
| b_cnt | input | 16 | Port B address counter |
| rd_data | output | 8 | Read data |

## Verification
The bench sweeps all 128 combinations of the status inputs and all 128 masks. For each mask it reads one full lap of the list plus two extra reads.

- A design with wrong wrap logic would repeat the last entry or skip the first one on the second lap.
- A design with a swapped counter byte would return the wrong half of a counter.
- Strobe collisions are checked on purpose. A design that let a read advance win over a rebuild would start the new list one entry late.
- Status is changed between reads of a status-plus-counter list. A design that held a snapshot would return stale match and end-of-block bits.

// File: rtl/dma_rb_pkg.sv
package dma_rb_pkg;
  localparam logic [7:0] STATUS_BASE = 8'hCC;

  function automatic logic [7:0] make_status(
    input logic       en,
    input logic [1:0] mode,
    input logic       pol,
    input logic       rdy,
    input logic       match,
    input logic       eob
  );
    logic [7:0] s;
    s    = STATUS_BASE;
    s[0] = en;
    s[1] = (mode != 2'd1) && (pol != rdy);
    s[4] = ~match;
    s[5] = ~eob;
    return s;
  endfunction
endpackage

// File: rtl/rb_status_gen.sv
module rb_status_gen
  import dma_rb_pkg::*;
(
  input  logic       chan_en,
  input  logic [1:0] xfer_mode,
  input  logic       rdy_pol,
  input  logic       rdy_in,
  input  logic       match_hit,
  input  logic       block_end,
  output logic [7:0] status_o
);
  always_comb begin
    status_o = make_status(chan_en, xfer_mode, rdy_pol, rdy_in, match_hit, block_end);
  end
endmodule

// File: rtl/rb_seq_ptr.sv
module rb_seq_ptr #(
  parameter int ENTRIES = 7,
  localparam int PTR_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_adv,
  input  logic               mask_we,
  input  logic [ENTRIES-1:0] mask_in,
  input  logic               restart,
  input  logic               status_only,
  output logic [ENTRIES-1:0] mask_q,
  output logic [PTR_W-1:0]   ptr_q
);
  logic [ENTRIES-1:0] new_mask;
  logic [ENTRIES-1:0] above;
  logic [PTR_W-1:0]   first_new;
  logic [PTR_W-1:0]   first_cur;
  logic [PTR_W-1:0]   next_idx;
  logic               rebuild;

  assign rebuild = status_only | mask_we | restart;

  always_comb begin
    if (status_only)  new_mask = ENTRIES'(1);
    else if (mask_we) new_mask = mask_in;
    else              new_mask = mask_q;
  end

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_above
      assign above[g] = mask_q[g] && (PTR_W'(g) > ptr_q);
    end
  endgenerate

  always_comb begin
    first_new = '0;
    first_cur = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (new_mask[i]) first_new = PTR_W'(i);
      if (mask_q[i])   first_cur = PTR_W'(i);
    end
    next_idx = first_cur;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (above[i]) next_idx = PTR_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      ptr_q  <= '0;
    end else if (rebuild) begin
      mask_q <= new_mask;
      ptr_q  <= first_new;
    end else if (rd_adv && (mask_q != '0)) begin
      ptr_q  <= next_idx;
    end
  end

  assert_ptr_selected_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q != '0) |-> mask_q[ptr_q]);
  assert_single_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rebuild && rd_adv && $countones(mask_q) == 1) |=> $stable(ptr_q));
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rebuild && !rd_adv) |=> ($stable(ptr_q) && $stable(mask_q)));
  assert_status_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    status_only |=> (mask_q == ENTRIES'(1) && ptr_q == '0));
  assert_restart_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !status_only && !mask_we) |=> $stable(mask_q));
endmodule

// File: rtl/rb_mux.sv
module rb_mux #(
  parameter int CNT_W = 16,
  localparam int CNT_BYTES = CNT_W / 8,
  localparam int ENTRIES = 1 + 3 * CNT_BYTES,
  localparam int PTR_W = $clog2(ENTRIES)
) (
  input  logic [PTR_W-1:0] sel,
  input  logic             list_empty,
  input  logic [7:0]       status_i,
  input  logic [CNT_W-1:0] byte_cnt,
  input  logic [CNT_W-1:0] a_cnt,
  input  logic [CNT_W-1:0] b_cnt,
  output logic [7:0]       data_o
);
  logic [7:0]       ent [ENTRIES];
  logic [CNT_W-1:0] cnts [3];

  assign cnts[0] = byte_cnt;
  assign cnts[1] = a_cnt;
  assign cnts[2] = b_cnt;
  assign ent[0]  = status_i;

  genvar c, b;
  generate
    for (c = 0; c < 3; c++) begin : g_cnt
      for (b = 0; b < CNT_BYTES; b++) begin : g_byte
        assign ent[1 + c * CNT_BYTES + b] = cnts[c][b*8 +: 8];
      end
    end
  endgenerate

  always_comb begin
    data_o = status_i;
    if (!list_empty) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (sel == PTR_W'(i)) data_o = ent[i];
      end
    end
  end
endmodule

// File: rtl/dma_readback.sv
module dma_readback #(
  parameter int CNT_W = 16,
  localparam int CNT_BYTES = CNT_W / 8,
  localparam int ENTRIES = 1 + 3 * CNT_BYTES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic               mask_we,
  input  logic [ENTRIES-1:0] mask_in,
  input  logic               restart_seq,
  input  logic               status_only,
  input  logic               chan_en,
  input  logic [1:0]         xfer_mode,
  input  logic               rdy_pol,
  input  logic               rdy_in,
  input  logic               match_hit,
  input  logic               block_end,
  input  logic [CNT_W-1:0]   byte_cnt,
  input  logic [CNT_W-1:0]   a_cnt,
  input  logic [CNT_W-1:0]   b_cnt,
  output logic [7:0]         rd_data
);
  localparam int PTR_W = $clog2(ENTRIES);

  logic [7:0]         status_live;
  logic [ENTRIES-1:0] mask_q;
  logic [PTR_W-1:0]   ptr_q;

  rb_status_gen u_stat (
    .chan_en(chan_en), .xfer_mode(xfer_mode), .rdy_pol(rdy_pol), .rdy_in(rdy_in),
    .match_hit(match_hit), .block_end(block_end), .status_o(status_live)
  );

  rb_seq_ptr #(.ENTRIES(ENTRIES)) u_seq (
    .clk(clk), .rst_n(rst_n), .rd_adv(rd_en), .mask_we(mask_we), .mask_in(mask_in),
    .restart(restart_seq), .status_only(status_only), .mask_q(mask_q), .ptr_q(ptr_q)
  );

  rb_mux #(.CNT_W(CNT_W)) u_mux (
    .sel(ptr_q), .list_empty(mask_q == '0), .status_i(status_live),
    .byte_cnt(byte_cnt), .a_cnt(a_cnt), .b_cnt(b_cnt), .data_o(rd_data)
  );

  assert_empty_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> (rd_data == status_live));
  assert_base_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> (rd_data[7:6] == 2'b11 && rd_data[3:2] == 2'b11 && rd_data[0] == chan_en));
  assert_status_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q != '0 && ptr_q == '0) |-> (rd_data == status_live));
endmodule

// File: tb/sim_dma_readback.sv
`timescale 1ns/1ps
module sim_dma_readback;
  logic clk = 0;
  logic rst_n = 0;
  logic rd_en = 0, mask_we = 0, restart_seq = 0, status_only = 0;
  logic [6:0] mask_in = '0;
  logic chan_en = 0, rdy_pol = 0, rdy_in = 0, match_hit = 0, block_end = 0;
  logic [1:0] xfer_mode = 0;
  logic [15:0] byte_cnt = 0, a_cnt = 0, b_cnt = 0;
  logic [7:0] rd_data;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dma_readback u0 (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .mask_we(mask_we), .mask_in(mask_in),
    .restart_seq(restart_seq), .status_only(status_only), .chan_en(chan_en),
    .xfer_mode(xfer_mode), .rdy_pol(rdy_pol), .rdy_in(rdy_in), .match_hit(match_hit),
    .block_end(block_end), .byte_cnt(byte_cnt), .a_cnt(a_cnt), .b_cnt(b_cnt),
    .rd_data(rd_data)
  );

  function automatic logic [7:0] exp_status();
    logic [7:0] s;
    s = 8'b1100_1100;
    s[0] = chan_en;
    s[1] = (xfer_mode != 2'd1) && (rdy_pol != rdy_in);
    s[4] = !match_hit;
    s[5] = !block_end;
    return s;
  endfunction

  function automatic logic [7:0] exp_entry(int i);
    case (i)
      0: return exp_status();
      1: return byte_cnt[7:0];
      2: return byte_cnt[15:8];
      3: return a_cnt[7:0];
      4: return a_cnt[15:8];
      5: return b_cnt[7:0];
      default: return b_cnt[15:8];
    endcase
  endfunction

  function automatic int nth_set(logic [6:0] m, int n);
    int k = 0;
    for (int i = 0; i < 7; i++) begin
      if (m[i]) begin
        if (k == n) return i;
        k++;
      end
    end
    return 0;
  endfunction

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic do_read(string req, int idx);
    @(negedge clk);
    rd_en = 1;
    #1 check(req, rd_data, exp_entry(idx));
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic load_mask(logic [6:0] m);
    @(negedge clk);
    mask_in = m; mask_we = 1;
    @(negedge clk);
    mask_we = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    chan_en = 1; match_hit = 1;
    #12 rst_n = 1;
    // R11: empty mask after reset, live status
    do_read("R11 reset live status", 0);
    do_read("R11 reset repeat", 0);

    // R1 R2 R3: status sweep with empty mask (R6)
    for (int v = 0; v < 128; v++) begin
      @(negedge clk);
      {chan_en, xfer_mode, rdy_pol, rdy_in, match_hit, block_end} = 7'(v);
      do_read("R1/R2/R3 status sweep R6", 0);
    end

    // R4 R5 R7: every mask, one lap plus two
    for (int m = 0; m < 128; m++) begin
      int k;
      @(negedge clk);
      byte_cnt = 16'(m * 16'h0103) ^ 16'h5A3C;
      a_cnt    = 16'(m * 16'h0207) ^ 16'hC3A1;
      b_cnt    = 16'(m * 16'h0409) ^ 16'h1E74;
      {chan_en, xfer_mode, rdy_pol, rdy_in, match_hit, block_end} = 7'(m * 37);
      load_mask(7'(m));
      k = $countones(7'(m));
      for (int r = 0; r < k + 2; r++) begin
        if (k == 0) do_read("R6 empty mask read", 0);
        else do_read("R4/R5/R7 sequence", nth_set(7'(m), r % k));
      end
    end

    // R9: restart returns to first selected
    load_mask(7'h2A);
    do_read("R9 pre", 1);
    do_read("R9 pre", 3);
    @(negedge clk); restart_seq = 1; @(negedge clk); restart_seq = 0;
    do_read("R9 restart first", 1);
    do_read("R9 restart second", 3);

    // R8: status only
    load_mask(7'h7E);
    do_read("R8 pre", 1);
    @(negedge clk); status_only = 1; @(negedge clk); status_only = 0;
    do_read("R8 status only", 0);
    do_read("R8 status only repeat", 0);

    // R10: status entry is live at its read
    load_mask(7'h03);
    match_hit = 1; block_end = 0;
    do_read("R10 status match", 0);
    do_read("R10 counter", 1);
    match_hit = 0; block_end = 1;
    do_read("R10 status changed", 0);

    // R12: status_only beats mask_we in same cycle
    @(negedge clk); status_only = 1; mask_we = 1; mask_in = 7'h7E;
    @(negedge clk); status_only = 0; mask_we = 0;
    do_read("R12 status_only over mask_we", 0);
    do_read("R12 status_only over mask_we again", 0);
    // R12: rebuild overrides read advance
    load_mask(7'h54);
    do_read("R12 setup", 2);
    @(negedge clk); rd_en = 1; restart_seq = 1;
    #1 check("R12 read during restart", rd_data, exp_entry(4));
    @(negedge clk); rd_en = 0; restart_seq = 0;
    do_read("R12 restart wins over advance", 2);
    // R12: mask_we beats restart
    @(negedge clk); mask_we = 1; restart_seq = 1; mask_in = 7'h18;
    @(negedge clk); mask_we = 0; restart_seq = 0;
    do_read("R12 mask_we over restart", 3);
    do_read("R12 mask_we over restart next", 4);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule